// File: doc/BRIEF.md
# Sequence-Keyed Timestamp Queue

This block holds receive timestamps for precision time protocol event messages until software asks for them. Each stored entry carries a 16-bit sequence key along with a seconds value and a nanoseconds value. There are four independent circular queues, one for each message class: sync, delay request, peer delay request and peer delay response. A push port writes one entry into the queue chosen by a class code.

A lookup names a class and a key. The block walks that queue from the oldest entry toward the newest, one entry per clock. It stops at the first entry whose key matches. On a hit it returns the stored stamp and drops the matching entry together with every entry older than it. On a miss it empties that queue. Pushes are held off with backpressure while a walk is running. A single flush input empties all four queues in one cycle.

The queues keep one slot free so that a full queue can be told apart from an empty one. A queue of `DEPTH` slots therefore holds at most `DEPTH-1` stamps.

Top module: `tsq_top`

## Requirements
- R1: Four queues are selected by a 2-bit class code (0 sync, 1 delay request, 2 peer delay request, 3 peer delay response). A stored key, seconds value and nanoseconds value come back unchanged on a hit.
- R2: A queue holds at most DEPTH-1 entries. A push accepted while the chosen queue is full is discarded, and the stored entries are left as they were.
- R3: A lookup examines entries from oldest to newest and answers with the first key match. When a key is duplicated, the older stamp comes back first.
- R4: On a hit, the matched entry and every older entry in that queue are removed, and newer entries stay.
- R5: A lookup that finds no match in a non-empty queue answers not-found and leaves that queue empty.
- R6: A lookup on an empty queue answers not-found on the same clock edge that accepts it.
- R7: Flush empties all four queues on its edge. A lookup being walked, or accepted, on that edge answers not-found. A push on that edge is discarded.
- R8: The accepting edge counts as edge 0. The response (rsp_valid high for one cycle) is registered at edge k+1 for a hit on the entry at position k (0 is the oldest), and at edge n for a miss over n entries.
- R9: push_ready and lk_ready are high whenever no walk is running, including just after reset. Both are low while a walk runs, and no queue changes occupancy during the walk.
- R10: Read and write positions wrap modulo DEPTH, so push and lookup keep working across the end of the storage.
- R11: A lookup, hit or miss, changes only the queue of its own class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empty all queues |
| push_valid | input | 1 | Push request |
| push_ready | output | 1 | Push may be accepted this cycle |
| push_class | input | 2 | Class code of the pushed stamp |
| push_key | input | KEY_W | Sequence key of the pushed stamp |
| push_sec | input | SEC_W | Seconds field of the pushed stamp |
| push_nsec | input | NS_W | Nanoseconds field of the pushed stamp |
| lk_valid | input | 1 | Lookup request |
| lk_ready | output | 1 | Lookup may be accepted this cycle |
| lk_class | input | 2 | Class code to search |
| lk_key | input | KEY_W | Key to search for |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_found | output | 1 | Response carries a matching stamp |
| rsp_sec | output | SEC_W | Seconds of the matching stamp (valid when found) |
| rsp_nsec | output | NS_W | Nanoseconds of the matching stamp (valid when found) |

## Verification
The bound checker watches several properties on every cycle:
- no queue changes occupancy while a walk runs;
- a push into a full queue leaves it at DEPTH-1;
- a miss leaves the searched queue empty;
- a hit shrinks it;
- flush empties every queue, and ends a running walk with not-found;
- a found answer only follows a walk cycle.

Some behaviours can only be shown by the directed scenarios in the bench: returned stamp values, oldest-first choice among duplicated keys, survival of newer entries after a hit, exact response latency, wrap-around over many rounds, and isolation between classes.

// File: rtl/tsq_pkg.sv
`timescale 1ns/1ps
package tsq_pkg;
  localparam int unsigned NUM_CLASSES = 4;

  typedef enum logic [1:0] {
    CLS_SYNC     = 2'd0,
    CLS_DLY_REQ  = 2'd1,
    CLS_PDLY_REQ = 2'd2,
    CLS_PDLY_RSP = 2'd3
  } ts_class_e;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scan_state_e;
endpackage

// File: rtl/tsq_ring.sv
`timescale 1ns/1ps
module tsq_ring #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned AW    = 8,
  parameter int unsigned EW    = 96
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr_en,
  input  logic [EW-1:0] wr_data,
  input  logic          head_ld,
  input  logic [AW-1:0] head_nxt,
  input  logic [AW-1:0] rd_ptr,
  output logic [EW-1:0] rd_data,
  output logic [AW-1:0] head,
  output logic [AW-1:0] tail,
  output logic [AW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          wr_drop
);
  logic [EW-1:0] mem [DEPTH];
  logic          wr_ok;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [AW-1:0] occupancy(input logic [AW-1:0] h, input logic [AW-1:0] t);
    return (t >= h) ? (t - h) : (AW'(DEPTH) - (h - t));
  endfunction

  assign count   = occupancy(head, tail);
  assign full    = (count == AW'(DEPTH - 1));
  assign empty   = (head == tail);
  assign wr_ok   = wr_en && !full && !flush;
  assign wr_drop = wr_en && full && !flush;
  assign rd_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[tail] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
    end else if (flush) begin
      head <= '0;
      tail <= '0;
    end else begin
      if (wr_ok)   tail <= ptr_inc(tail);
      if (head_ld) head <= head_nxt;
    end
  end
endmodule

// File: rtl/tsq_scan.sv
`timescale 1ns/1ps
module tsq_scan
  import tsq_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned KEY_W = 16,
  parameter int unsigned SEC_W = 48,
  parameter int unsigned NS_W  = 32,
  parameter int unsigned AW    = 8,
  parameter int unsigned EW    = 96
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             lk_valid,
  input  logic [1:0]       lk_class,
  input  logic [KEY_W-1:0] lk_key,
  output logic             lk_ready,
  input  logic [AW-1:0]    sel_head,
  input  logic [AW-1:0]    sel_tail,
  input  logic [EW-1:0]    cur_entry,
  output logic [1:0]       cls_q,
  output logic [AW-1:0]    cursor,
  output logic             head_ld,
  output logic [AW-1:0]    head_nxt,
  output logic             rsp_valid,
  output logic             rsp_found,
  output logic [SEC_W-1:0] rsp_sec,
  output logic [NS_W-1:0]  rsp_nsec,
  output logic             busy,
  output logic             scan_hit,
  output logic             scan_miss,
  output logic             empty_miss
);
  scan_state_e      state_q;
  logic [KEY_W-1:0] key_q;
  logic [KEY_W-1:0] e_key;
  logic [SEC_W-1:0] e_sec;
  logic [NS_W-1:0]  e_ns;
  logic [AW-1:0]    nxt;
  logic             lk_fire;
  logic             key_eq;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign e_key = cur_entry[EW-1 -: KEY_W];
  assign e_sec = cur_entry[SEC_W+NS_W-1 -: SEC_W];
  assign e_ns  = cur_entry[NS_W-1:0];

  assign busy       = (state_q == ST_SCAN);
  assign lk_ready   = !busy;
  assign lk_fire    = lk_valid && lk_ready;
  assign key_eq     = (e_key == key_q);
  assign nxt        = ptr_inc(cursor);
  assign scan_hit   = busy && !flush && key_eq;
  assign scan_miss  = busy && !flush && !key_eq && (nxt == sel_tail);
  assign empty_miss = lk_fire && !flush && (sel_head == sel_tail);
  assign head_ld    = scan_hit || scan_miss;
  assign head_nxt   = scan_hit ? nxt : sel_tail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      key_q     <= '0;
      cls_q     <= '0;
      cursor    <= '0;
      rsp_valid <= 1'b0;
      rsp_found <= 1'b0;
      rsp_sec   <= '0;
      rsp_nsec  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (flush) begin
        if (busy || lk_fire) begin
          rsp_valid <= 1'b1;
          rsp_found <= 1'b0;
        end
        state_q <= ST_IDLE;
      end else if (!busy) begin
        if (lk_fire) begin
          cls_q  <= lk_class;
          key_q  <= lk_key;
          cursor <= sel_head;
          if (sel_head == sel_tail) begin
            rsp_valid <= 1'b1;
            rsp_found <= 1'b0;
          end else begin
            state_q <= ST_SCAN;
          end
        end
      end else if (scan_hit) begin
        rsp_valid <= 1'b1;
        rsp_found <= 1'b1;
        rsp_sec   <= e_sec;
        rsp_nsec  <= e_ns;
        state_q   <= ST_IDLE;
      end else if (scan_miss) begin
        rsp_valid <= 1'b1;
        rsp_found <= 1'b0;
        state_q   <= ST_IDLE;
      end else begin
        cursor <= nxt;
      end
    end
  end
endmodule

// File: rtl/tsq_top.sv
`timescale 1ns/1ps
module tsq_top
  import tsq_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned KEY_W = 16,
  parameter int unsigned SEC_W = 48,
  parameter int unsigned NS_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push_valid,
  output logic             push_ready,
  input  logic [1:0]       push_class,
  input  logic [KEY_W-1:0] push_key,
  input  logic [SEC_W-1:0] push_sec,
  input  logic [NS_W-1:0]  push_nsec,
  input  logic             lk_valid,
  output logic             lk_ready,
  input  logic [1:0]       lk_class,
  input  logic [KEY_W-1:0] lk_key,
  output logic             rsp_valid,
  output logic             rsp_found,
  output logic [SEC_W-1:0] rsp_sec,
  output logic [NS_W-1:0]  rsp_nsec
);
  localparam int unsigned NCLS = NUM_CLASSES;
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned EW   = KEY_W + SEC_W + NS_W;

  logic [NCLS-1:0][AW-1:0] head_a;
  logic [NCLS-1:0][AW-1:0] tail_a;
  logic [NCLS-1:0][AW-1:0] cnt_a;
  logic [NCLS-1:0][EW-1:0] rd_a;
  logic [NCLS-1:0]         full_a;
  logic [NCLS-1:0]         empty_a;
  logic [NCLS-1:0]         drop_a;

  logic [EW-1:0] push_entry;
  logic [1:0]    cls_q;
  logic [1:0]    sel_cls;
  logic [AW-1:0] cursor;
  logic [AW-1:0] head_nxt;
  logic          head_ld;
  logic          busy;
  logic          push_fire;
  logic          push_drop;
  logic          scan_hit;
  logic          scan_miss;
  logic          empty_miss;
  logic          all_empty;

  assign push_ready = !busy;
  assign push_fire  = push_valid && push_ready;
  assign push_entry = {push_key, push_sec, push_nsec};
  assign sel_cls    = busy ? cls_q : lk_class;
  assign push_drop  = |drop_a;
  assign all_empty  = &empty_a;

  for (genvar c = 0; c < NCLS; c++) begin : g_ring
    tsq_ring #(.DEPTH(DEPTH), .AW(AW), .EW(EW)) u_ring (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (flush),
      .wr_en   (push_fire && (push_class == 2'(c))),
      .wr_data (push_entry),
      .head_ld (head_ld && (cls_q == 2'(c))),
      .head_nxt(head_nxt),
      .rd_ptr  (cursor),
      .rd_data (rd_a[c]),
      .head    (head_a[c]),
      .tail    (tail_a[c]),
      .count   (cnt_a[c]),
      .full    (full_a[c]),
      .empty   (empty_a[c]),
      .wr_drop (drop_a[c])
    );
  end

  tsq_scan #(
    .DEPTH(DEPTH), .KEY_W(KEY_W), .SEC_W(SEC_W), .NS_W(NS_W), .AW(AW), .EW(EW)
  ) u_scan (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .lk_valid  (lk_valid),
    .lk_class  (lk_class),
    .lk_key    (lk_key),
    .lk_ready  (lk_ready),
    .sel_head  (head_a[sel_cls]),
    .sel_tail  (tail_a[sel_cls]),
    .cur_entry (rd_a[cls_q]),
    .cls_q     (cls_q),
    .cursor    (cursor),
    .head_ld   (head_ld),
    .head_nxt  (head_nxt),
    .rsp_valid (rsp_valid),
    .rsp_found (rsp_found),
    .rsp_sec   (rsp_sec),
    .rsp_nsec  (rsp_nsec),
    .busy      (busy),
    .scan_hit  (scan_hit),
    .scan_miss (scan_miss),
    .empty_miss(empty_miss)
  );
endmodule

// File: rtl/tsq_checks.sv
`timescale 1ns/1ps
module tsq_checks #(
  parameter int unsigned NCLS  = 4,
  parameter int unsigned AW    = 8,
  parameter int unsigned DEPTH = 256
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    flush,
  input logic                    push_fire,
  input logic                    push_drop,
  input logic [1:0]              push_class,
  input logic                    busy,
  input logic                    rsp_valid,
  input logic                    rsp_found,
  input logic                    scan_hit,
  input logic                    scan_miss,
  input logic                    empty_miss,
  input logic [1:0]              cls_q,
  input logic [NCLS-1:0][AW-1:0] cnt_a,
  input logic [NCLS-1:0]         full_a,
  input logic                    all_empty
);
  logic [AW-1:0] sel_cnt;
  assign sel_cnt = cnt_a[cls_q];

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    // R9: no occupancy change in any queue while a walk is in progress
    a_r9_frozen_during_scan: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !scan_hit && !scan_miss && !flush |=> $stable(cnt_a[c]));
    // R2: a push into a full queue leaves it at its limit
    a_r2_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
      full_a[c] && push_fire && (push_class == 2'(c)) && !flush |=> cnt_a[c] == AW'(DEPTH - 1));
  end

  a_r2_drop_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop |-> full_a[push_class]);
  a_r5_miss_empties: assert property (@(posedge clk) disable iff (!rst_n)
    scan_miss |=> sel_cnt == '0);
  a_r4_hit_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    scan_hit |=> sel_cnt < $past(sel_cnt));
  a_r6_empty_answers: assert property (@(posedge clk) disable iff (!rst_n)
    empty_miss |=> rsp_valid && !rsp_found);
  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> all_empty);
  a_r7_flush_ends_walk: assert property (@(posedge clk) disable iff (!rst_n)
    flush && busy |=> rsp_valid && !rsp_found && !busy);
  a_r3_found_after_walk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_found |-> $past(busy));
endmodule

bind tsq_top tsq_checks #(.NCLS(NCLS), .AW(AW), .DEPTH(DEPTH)) u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .flush     (flush),
  .push_fire (push_fire),
  .push_drop (push_drop),
  .push_class(push_class),
  .busy      (busy),
  .rsp_valid (rsp_valid),
  .rsp_found (rsp_found),
  .scan_hit  (scan_hit),
  .scan_miss (scan_miss),
  .empty_miss(empty_miss),
  .cls_q     (cls_q),
  .cnt_a     (cnt_a),
  .full_a    (full_a),
  .all_empty (all_empty)
);

// File: tb/sim_tsq_top.sv
`timescale 1ns/1ps
module sim_tsq_top;
  import tsq_pkg::*;

  localparam int unsigned D     = 16;
  localparam int unsigned KEY_W = 16;
  localparam int unsigned SEC_W = 48;
  localparam int unsigned NS_W  = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic push_valid = 1'b0;
  logic push_ready;
  logic [1:0] push_class = '0;
  logic [KEY_W-1:0] push_key = '0;
  logic [SEC_W-1:0] push_sec = '0;
  logic [NS_W-1:0] push_nsec = '0;
  logic lk_valid = 1'b0;
  logic lk_ready;
  logic [1:0] lk_class = '0;
  logic [KEY_W-1:0] lk_key = '0;
  logic rsp_valid, rsp_found;
  logic [SEC_W-1:0] rsp_sec;
  logic [NS_W-1:0] rsp_nsec;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  tsq_top #(.DEPTH(D), .KEY_W(KEY_W), .SEC_W(SEC_W), .NS_W(NS_W)) u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push_valid(push_valid), .push_ready(push_ready), .push_class(push_class),
    .push_key(push_key), .push_sec(push_sec), .push_nsec(push_nsec),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_class(lk_class), .lk_key(lk_key),
    .rsp_valid(rsp_valid), .rsp_found(rsp_found), .rsp_sec(rsp_sec), .rsp_nsec(rsp_nsec)
  );

  function automatic logic [SEC_W-1:0] exp_sec(input int k);
    return SEC_W'(48'h0001_0000_0000 + 64'(k) * 3);
  endfunction
  function automatic logic [NS_W-1:0] exp_ns(input int k);
    return NS_W'(32'h0A00_0000 + k * 7);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  task automatic do_push(input logic [1:0] cls, input int key,
                         input logic [SEC_W-1:0] s, input logic [NS_W-1:0] ns);
    @(negedge clk);
    push_valid = 1'b1; push_class = cls; push_key = KEY_W'(key);
    push_sec = s; push_nsec = ns;
    @(negedge clk);
    push_valid = 1'b0;
  endtask

  task automatic push_std(input logic [1:0] cls, input int key);
    do_push(cls, key, exp_sec(key), exp_ns(key));
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  // lat counts edges after the accepting one
  task automatic do_lookup(input logic [1:0] cls, input int key, output bit found,
                           output logic [SEC_W-1:0] s, output logic [NS_W-1:0] ns,
                           output int lat);
    @(negedge clk);
    lk_valid = 1'b1; lk_class = cls; lk_key = KEY_W'(key);
    @(negedge clk);
    lk_valid = 1'b0;
    lat = 0;
    while (!rsp_valid && lat < 4 * D + 8) begin
      @(negedge clk);
      lat++;
    end
    found = rsp_found; s = rsp_sec; ns = rsp_nsec;
    check(rsp_valid, "R8", "response arrived", 0, 1);
  endtask

  task automatic expect_hit(input string req, input logic [1:0] cls, input int key,
                            input int exp_lat, input logic [SEC_W-1:0] es,
                            input logic [NS_W-1:0] en);
    bit f; logic [SEC_W-1:0] s; logic [NS_W-1:0] ns; int lat;
    do_lookup(cls, key, f, s, ns, lat);
    check(f == 1'b1, req, "found", f, 1);
    check(s == es, req, "seconds", s, es);
    check(ns == en, req, "nanoseconds", ns, en);
    check(lat == exp_lat, "R8", "hit latency", lat, exp_lat);
  endtask

  task automatic expect_miss(input string req, input logic [1:0] cls, input int key,
                             input int exp_lat);
    bit f; logic [SEC_W-1:0] s; logic [NS_W-1:0] ns; int lat;
    do_lookup(cls, key, f, s, ns, lat);
    check(f == 1'b0, req, "not found", f, 0);
    check(lat == exp_lat, req, "miss latency", lat, exp_lat);
  endtask

  task automatic t_reset();
    check(push_ready == 1'b1, "R9", "push_ready after reset", push_ready, 1);
    check(lk_ready == 1'b1, "R9", "lk_ready after reset", lk_ready, 1);
    check(rsp_valid == 1'b0, "R9", "rsp_valid after reset", rsp_valid, 0);
  endtask

  task automatic t_basic();
    push_std(CLS_SYNC, 10); push_std(CLS_SYNC, 11); push_std(CLS_SYNC, 12);
    expect_hit("R1", CLS_SYNC, 11, 2, exp_sec(11), exp_ns(11));
    expect_hit("R4", CLS_SYNC, 12, 1, exp_sec(12), exp_ns(12));
    expect_miss("R6", CLS_SYNC, 12, 0);
  endtask

  task automatic t_discard();
    push_std(CLS_DLY_REQ, 1); push_std(CLS_DLY_REQ, 2); push_std(CLS_DLY_REQ, 3);
    expect_hit("R4", CLS_DLY_REQ, 2, 2, exp_sec(2), exp_ns(2));
    expect_miss("R4", CLS_DLY_REQ, 1, 1);
    expect_miss("R5", CLS_DLY_REQ, 3, 0);
  endtask

  task automatic t_miss();
    push_std(CLS_PDLY_REQ, 5); push_std(CLS_PDLY_REQ, 6); push_std(CLS_PDLY_REQ, 7);
    expect_miss("R5", CLS_PDLY_REQ, 9, 3);
    expect_miss("R5", CLS_PDLY_REQ, 5, 0);
  endtask

  task automatic t_dup();
    do_push(CLS_PDLY_RSP, 7, 48'd111, 32'd11);
    do_push(CLS_PDLY_RSP, 7, 48'd222, 32'd22);
    expect_hit("R3", CLS_PDLY_RSP, 7, 1, 48'd111, 32'd11);
    expect_hit("R3", CLS_PDLY_RSP, 7, 1, 48'd222, 32'd22);
  endtask

  task automatic t_isolate();
    push_std(CLS_SYNC, 20);
    do_push(CLS_DLY_REQ, 20, 48'd999, 32'd9);
    expect_miss("R11", CLS_DLY_REQ, 99, 1);
    expect_hit("R11", CLS_SYNC, 20, 1, exp_sec(20), exp_ns(20));
  endtask

  task automatic t_busy();
    int lat;
    for (int k = 40; k < 44; k++) push_std(CLS_PDLY_REQ, k);
    @(negedge clk);
    lk_valid = 1'b1; lk_class = CLS_PDLY_REQ; lk_key = 16'd43;
    @(negedge clk);
    lk_valid = 1'b0;
    push_valid = 1'b1; push_class = CLS_PDLY_REQ; push_key = 16'd50;
    push_sec = exp_sec(50); push_nsec = exp_ns(50);
    lat = 0;
    while (!rsp_valid && lat < 20) begin
      check(push_ready == 1'b0, "R9", "push_ready during walk", push_ready, 0);
      check(lk_ready == 1'b0, "R9", "lk_ready during walk", lk_ready, 0);
      @(negedge clk);
      lat++;
    end
    check(lat == 4, "R8", "walk latency pos 3", lat, 4);
    check(rsp_found == 1'b1 && rsp_sec == exp_sec(43), "R9", "stamp of key 43",
          rsp_sec, exp_sec(43));
    check(push_ready == 1'b1, "R9", "push_ready after walk", push_ready, 1);
    @(negedge clk);
    push_valid = 1'b0;
    expect_hit("R9", CLS_PDLY_REQ, 50, 1, exp_sec(50), exp_ns(50));
  endtask

  task automatic t_full();
    do_flush();
    for (int k = 0; k < D - 1; k++) push_std(CLS_SYNC, 100 + k);
    push_std(CLS_SYNC, 200);
    expect_hit("R2", CLS_SYNC, 100 + D - 2, D - 1, exp_sec(100 + D - 2), exp_ns(100 + D - 2));
    expect_miss("R2", CLS_SYNC, 200, 0);
  endtask

  task automatic t_wrap();
    do_flush();
    for (int i = 0; i < 40; i++) begin
      push_std(CLS_PDLY_RSP, 300 + i);
      expect_hit("R10", CLS_PDLY_RSP, 300 + i, 1, exp_sec(300 + i), exp_ns(300 + i));
    end
  endtask

  task automatic t_flush();
    do_flush();
    for (int k = 60; k < 65; k++) push_std(CLS_SYNC, k);
    push_std(CLS_DLY_REQ, 65);
    @(negedge clk);
    lk_valid = 1'b1; lk_class = CLS_SYNC; lk_key = 16'd99;
    @(negedge clk);
    lk_valid = 1'b0;
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    check(rsp_valid == 1'b1, "R7", "walk ended by flush", rsp_valid, 1);
    check(rsp_found == 1'b0, "R7", "flush answer not found", rsp_found, 0);
    expect_miss("R7", CLS_DLY_REQ, 65, 0);
    expect_miss("R7", CLS_SYNC, 60, 0);
    @(negedge clk);
    flush = 1'b1; push_valid = 1'b1; push_class = CLS_PDLY_REQ; push_key = 16'd70;
    push_sec = exp_sec(70); push_nsec = exp_ns(70);
    @(negedge clk);
    flush = 1'b0; push_valid = 1'b0;
    expect_miss("R7", CLS_PDLY_REQ, 70, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cyc, 150000);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_discard();
    t_miss();
    t_dup();
    t_isolate();
    t_busy();
    t_full();
    t_wrap();
    t_flush();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule